// File: doc/BRIEF.md
# Nibble-Serial Ethernet CRC-32 Engine

This block computes the 32-bit Ethernet frame check sequence over a frame that arrives four bits per clock. The register divides the incoming bit stream by the generator polynomial in augmented form. Bits enter at the low end of the register, and the generator is folded in whenever a one leaves the top. Because of this, the register holds the true remainder of everything seen so far, shifted by 32 bit positions.

A transmitter pushes the frame and then eight zero nibbles, and reads the CRC from the register. A receiver pushes the frame and then the received CRC, and reads zero when the frame is intact. A start pulse opens each frame. A last-nibble marker produces a one-cycle done pulse, and that pulse qualifies the good flag.

Top module: `crc_nibble_engine`

## Requirements
- R1: While reset is held and directly after it, the register reads the initial value (all zeros by default) and the done and good outputs are low.
- R2: A start pulse without a valid nibble loads the initial value in the next cycle. A start together with a valid nibble folds that nibble into the initial value, not into the old register.
- R3: While neither the valid strobe nor start is high, the register keeps its value, so idle cycles inside a frame do not change the result.
- R4: Each accepted nibble advances the register by four single-bit steps, bit 0 first. In each step the input bit enters at register bit 0, and 0x04C11DB7 is XORed in when the bit shifted out of bit 31 was one. A byte is sent as its low nibble first, then its high nibble. After a frame and eight zero nibbles, the register equals the frame's remainder multiplied by x^32 modulo the generator, with register bit 31 as the x^31 coefficient.
- R5: Suppose the eight trailer nibbles carry the value C that zero padding produced, with trailer nibble k bit j equal to C[31-4k-j]. Then the register reads zero after the last trailer nibble.
- R6: The done output is high for exactly the one cycle after an accepted nibble that was marked last, and low in every other cycle.
- R7: The zero output is high exactly when the register is zero. The good output is high exactly when done and zero are both high.
- R8: Flipping any single bit of a frame that carries its correct trailer leaves a nonzero register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a frame: load the initial value |
| nib_valid_i | input | 1 | nib_i carries a nibble to absorb this cycle |
| nib_last_i | input | 1 | The accepted nibble is the frame's final one |
| nib_i | input | 4 | Data nibble, bit 0 processed first |
| crc_o | output | 32 | Current register value |
| zero_o | output | 1 | Register equals zero |
| done_o | output | 1 | One-cycle pulse after the last nibble |
| good_o | output | 1 | done_o qualified by an all-zero register |

## Verification
The hardest case to reach is the zero residue. It appears only when the trailer is the exact remainder of the preceding bits, with every nibble and bit in the right order. Random stimulus never gets there. The bench therefore computes each remainder itself by polynomial long division over an explicit bit array. It feeds that remainder back, bit-reversed per nibble, as the trailer. This is done for a 512-bit reference frame and for every one-byte frame. It then flips each of the 512 frame bits in turn to show that the residue leaves zero.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int CRC_W = 32;
  typedef logic [CRC_W-1:0] crc_t;

  localparam crc_t ETH_POLY = 32'h04C11DB7;

  // One augmented division step: input bit enters at bit 0, the generator
  // is folded in when the bit leaving the top was a one.
  function automatic crc_t crc_bit_step(input crc_t cur, input logic din, input crc_t poly);
    crc_t shifted;
    shifted = {cur[CRC_W-2:0], din};
    return cur[CRC_W-1] ? (shifted ^ poly) : shifted;
  endfunction
endpackage

// File: rtl/crc_nib_step.sv
module crc_nib_step
  import crc_pkg::*;
#(
  parameter int   NIB_W = 4,
  parameter crc_t POLY  = ETH_POLY
) (
  input  crc_t             cur_i,
  input  logic [NIB_W-1:0] nib_i,
  output crc_t             nxt_o
);
  crc_t chain [0:NIB_W];

  assign chain[0] = cur_i;

  for (genvar g = 0; g < NIB_W; g++) begin : g_bit
    assign chain[g+1] = crc_bit_step(chain[g], nib_i[g], POLY);
  end

  assign nxt_o = chain[NIB_W];
endmodule

// File: rtl/crc_frame_ctl.sv
module crc_frame_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic accept_i,
  input  logic last_i,
  output logic done_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_o <= 1'b0;
    else        done_o <= accept_i & last_i;
  end
endmodule

// File: rtl/crc_nibble_engine.sv
module crc_nibble_engine
  import crc_pkg::*;
#(
  parameter int   NIB_W = 4,
  parameter crc_t POLY  = ETH_POLY,
  parameter crc_t INIT  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             nib_valid_i,
  input  logic             nib_last_i,
  input  logic [NIB_W-1:0] nib_i,
  output logic [CRC_W-1:0] crc_o,
  output logic             zero_o,
  output logic             done_o,
  output logic             good_o
);
  crc_t crc_q;
  crc_t base_sel;   // value the incoming nibble is folded into
  crc_t step_nxt;   // register after absorbing nib_i
  logic accept;
  logic done_w;

  assign accept   = nib_valid_i;
  assign base_sel = start_i ? INIT : crc_q;

  crc_nib_step #(.NIB_W(NIB_W), .POLY(POLY)) u_step (
    .cur_i (base_sel),
    .nib_i (nib_i),
    .nxt_o (step_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crc_q <= INIT;
    else if (accept)  crc_q <= step_nxt;
    else if (start_i) crc_q <= INIT;
  end

  crc_frame_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept),
    .last_i   (nib_last_i),
    .done_o   (done_w)
  );

  assign crc_o  = crc_q;
  assign zero_o = (crc_q == '0);
  assign done_o = done_w;
  assign good_o = done_w & zero_o;
endmodule

// File: rtl/crc_nibble_engine_chk.sv
module crc_nibble_engine_chk
  import crc_pkg::*;
#(
  parameter int   NIB_W = 4,
  parameter crc_t POLY  = ETH_POLY,
  parameter crc_t INIT  = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             nib_valid_i,
  input logic             nib_last_i,
  input logic [NIB_W-1:0] nib_i,
  input logic [CRC_W-1:0] crc_o,
  input logic             zero_o,
  input logic             done_o,
  input logic             good_o
);
  function automatic crc_t ref_nib(input crc_t cur, input logic [NIB_W-1:0] n);
    crc_t r;
    r = cur;
    for (int i = 0; i < NIB_W; i++) r = crc_bit_step(r, n[i], POLY);
    return r;
  endfunction

  AST_START_LOADS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !nib_valid_i |=> crc_o == INIT);  // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i && !nib_valid_i |=> $stable(crc_o));  // R3

  AST_NIBBLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    nib_valid_i |=> crc_o == ref_nib($past(start_i) ? INIT : $past(crc_o), $past(nib_i)));  // R4

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    nib_valid_i && nib_last_i |=> done_o);  // R6

  AST_DONE_ONLY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    !(nib_valid_i && nib_last_i) |=> !done_o);  // R6

  AST_GOOD_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    good_o |-> done_o && zero_o && crc_o == '0);  // R7
endmodule

bind crc_nibble_engine crc_nibble_engine_chk #(.NIB_W(NIB_W), .POLY(POLY), .INIT(INIT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .nib_valid_i (nib_valid_i),
  .nib_last_i  (nib_last_i),
  .nib_i       (nib_i),
  .crc_o       (crc_o),
  .zero_o      (zero_o),
  .done_o      (done_o),
  .good_o      (good_o)
);

// File: tb/crc_nibble_engine_test.sv
module crc_nibble_engine_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, nib_valid_i, nib_last_i;
  logic [3:0]  nib_i;
  logic [31:0] crc_o;
  logic        zero_o, done_o, good_o;

  always #2 clk = ~clk;  // 250 MHz

  crc_nibble_engine uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .nib_valid_i(nib_valid_i),
    .nib_last_i(nib_last_i), .nib_i(nib_i), .crc_o(crc_o), .zero_o(zero_o),
    .done_o(done_o), .good_o(good_o)
  );

  localparam logic [511:0] REF_FRAME = {
    48'h0010a47bea80, 48'h001234567890, 16'h0800,
    96'h4500002eb3fe000080110540, 32'hc0a8002c, 32'hc0a80004,
    8'h04, 8'h00, 16'h0400,
    208'h001a2de8000102030405060708090a0b0c0d0e0f101100000000};

  logic [7:0] msg [0:63];
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Long division of msg(x)*x^32 by the generator over an explicit bit list.
  function automatic logic [31:0] ref_rem(input int nbytes);
    logic        bits [0:543];
    logic [32:0] gen;
    logic [31:0] r;
    int          len;
    gen = 33'h104C11DB7;
    len = nbytes * 8;
    for (int i = 0; i < 544; i++) bits[i] = 1'b0;
    for (int b = 0; b < nbytes; b++)
      for (int j = 0; j < 8; j++) bits[b*8 + j] = msg[b][j];
    for (int i = 0; i < len; i++)
      if (bits[i])
        for (int k = 0; k <= 32; k++) bits[i+k] = bits[i+k] ^ gen[32-k];
    for (int k = 0; k < 32; k++) r[31-k] = bits[len+k];
    return r;
  endfunction

  task automatic put(input logic s, input logic v, input logic l, input logic [3:0] n);
    @(negedge clk);
    start_i = s; nib_valid_i = v; nib_last_i = l; nib_i = n;
  endtask

  task automatic idle();
    put(1'b0, 1'b0, 1'b0, 4'h0);
  endtask

  // pad=1: eight zero nibbles; pad=0: trailer tr, nibble k bit j = tr[31-4k-j]
  task automatic send_frame(input int nbytes, input bit pad, input logic [31:0] tr, input int gap);
    logic [3:0] n;
    for (int b = 0; b < nbytes; b++)
      for (int h = 0; h < 2; h++) begin
        n = h ? msg[b][7:4] : msg[b][3:0];
        put((b == 0 && h == 0), 1'b1, 1'b0, n);
        repeat (gap) idle();
      end
    for (int k = 0; k < 8; k++) begin
      for (int j = 0; j < 4; j++) n[j] = pad ? 1'b0 : tr[31-4*k-j];
      put(1'b0, 1'b1, (k == 7), n);
      if (k != 7) repeat (gap) idle();
    end
    idle();  // register and done now reflect the last nibble
  endtask

  task automatic load_ref();
    for (int i = 0; i < 64; i++) msg[i] = REF_FRAME[511-8*i -: 8];
  endtask

  initial begin
    #800000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_ref, exp_b;
    rst_n = 1'b0; start_i = 1'b0; nib_valid_i = 1'b0; nib_last_i = 1'b0; nib_i = 4'h0;
    repeat (3) @(negedge clk);
    check(crc_o == 32'h0, "R1 reset crc", crc_o, 32'h0);
    check(done_o == 1'b0 && good_o == 1'b0, "R1 reset flags", {30'h0, done_o, good_o}, 32'h0);
    rst_n = 1'b1;
    idle();
    check(crc_o == 32'h0 && zero_o, "R1 after reset", crc_o, 32'h0);

    // R2: stray nibbles then a bare start pulse
    put(1'b1, 1'b1, 1'b0, 4'hA);
    put(1'b0, 1'b1, 1'b0, 4'h5);
    put(1'b0, 1'b1, 1'b0, 4'hF);
    put(1'b1, 1'b0, 1'b0, 4'h0);
    idle();
    check(crc_o == 32'h0, "R2 start clears", crc_o, 32'h0);

    // Reference frame, zero padded
    load_ref();
    exp_ref = ref_rem(64);
    send_frame(64, 1'b1, 32'h0, 0);
    check(crc_o == exp_ref, "R4 reference pad", crc_o, exp_ref);
    check(done_o == 1'b1, "R6 done after last", {31'h0, done_o}, 32'h1);
    check(good_o == (exp_ref == 32'h0), "R7 good on nonzero", {31'h0, good_o}, 32'h0);
    idle();
    check(done_o == 1'b0, "R6 done one cycle", {31'h0, done_o}, 32'h0);
    check(crc_o == exp_ref, "R3 idle holds", crc_o, exp_ref);

    // R2: start with a valid nibble absorbs it from the initial value
    send_frame(64, 1'b0, exp_ref, 0);
    check(crc_o == 32'h0 && zero_o, "R5 reference residue", crc_o, 32'h0);
    check(good_o == 1'b1, "R7 good on zero", {31'h0, good_o}, 32'h1);
    check(crc_o == 32'h0, "R2 start with nibble", crc_o, 32'h0);

    // R3: idle gaps between nibbles do not change the result
    send_frame(64, 1'b1, 32'h0, 2);
    check(crc_o == exp_ref, "R3 gaps", crc_o, exp_ref);

    // R8: every single-bit error in the reference frame
    for (int bi = 0; bi < 512; bi++) begin
      load_ref();
      msg[bi/8][bi%8] = ~msg[bi/8][bi%8];
      send_frame(64, 1'b0, exp_ref, 0);
      check(crc_o != 32'h0 && !good_o, "R8 bit flip", crc_o, 32'h0);
    end

    // R4/R5: every one-byte frame
    for (int v = 0; v < 256; v++) begin
      msg[0] = v[7:0];
      exp_b = ref_rem(1);
      send_frame(1, 1'b1, 32'h0, 0);
      check(crc_o == exp_b, "R4 byte sweep", crc_o, exp_b);
      send_frame(1, 1'b0, exp_b, 0);
      check(crc_o == 32'h0 && good_o, "R5 byte sweep", crc_o, 32'h0);
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule